// File: doc/BRIEF.md
# Mode-Register Write Sequencer for Registered Memory Modules

This block sits between a memory controller's configuration logic and the command bus of a registered or load-reduced memory module. It takes one logical mode-register write (rank, register index, 18-bit payload) and drives it as one or two command-bus transactions, each with a parity bit. It fixes up the payload so that every device ends up holding the value that was asked for.

For odd-numbered ranks, whose address pins are cross-wired on the module, selected pairs of address, bank and bank-group bits are swapped. The register device inverts part of its outputs by default. For that case each DRAM write is issued twice: once for the A-side devices as computed, and once for the B-side devices with the invertible bits flipped. Register index 7 carries control words for the buffering devices. Payload bit 12 routes such a word either to the register device or to the data buffer. A control word is always sent once and unmodified.

The request side is a valid/ready stream. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. The requester must hold its request stable while `req_valid` is high and `req_ready` is low. `req_ready` stays low while a B-side copy is still pending and until the programmed command spacing has run out. The command bus has no back-pressure: a command is driven for exactly one cycle, qualified by `cmd_valid`.

Top module: `mrw_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and every bit of `cmd_cs_n` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Its first command appears with `cmd_valid`=1 and `cmd_bside`=0 in the cycle right after that edge. `req_ready` is 0 in any cycle where a B-side copy is still pending.
- R3: Before remapping, the 22-bit command word {BG1,BG0,BA1,BA0,A17..A0} is built as follows: bits 17..0 are the payload, BA0 is register index bit 0, BA1 is index bit 1, BG0 is index bit 2, and BG1 is 0. The driven word appears on `cmd_bg`, `cmd_ba` and `cmd_addr`.
- R4: For DRAM writes (indices 0 to 6) to an even rank, the word is driven unswapped. For an odd rank, these pairs are exchanged: A3/A4, A5/A6, A7/A8, A11/A13, BA0/BA1 and BG0/BG1. All other bits pass straight through.
- R5: With `inv_disable`=0, a DRAM write produces two commands. The first has `cmd_bside`=0 and carries the word after R4. The second has `cmd_bside`=1 and carries the same word with A3..A9, A11, A13, A17, BA0, BA1, BG0 and BG1 inverted. All other bits are unchanged.
- R6: With `inv_disable`=1, a DRAM write produces exactly one command, with `cmd_bside`=0, carrying the word after R4.
- R7: `cmd_tgt` is 0 for DRAM writes. A write to index 7 is a control word: `cmd_tgt` is 2 (data buffer) when payload bit 12 is 1, and 1 (register device) when it is 0. A control word is issued as a single command with no swap and no inversion, on any rank.
- R8: During every command, the number of ones in {`cmd_bg`,`cmd_ba`,`cmd_addr`,`cmd_par`} is even.
- R9: Two consecutive commands are issued at least max(`gap_cfg`,1) cycles apart. When the next command is already waiting (a B-side copy, or a request held valid), it follows after exactly that many cycles.
- R10: While `cmd_valid` is 1, exactly one bit of `cmd_cs_n` is 0, the one at the request's rank. While `cmd_valid` is 0, all bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_rank | input | RANK_W | Target rank |
| req_mr | input | 3 | Mode-register index |
| req_data | input | 18 | Payload for A17..A0 |
| inv_disable | input | 1 | 1 = register device does not invert; single command per write |
| gap_cfg | input | GAP_W | Minimum spacing between commands, in cycles |
| cmd_valid | output | 1 | Command strobe, one cycle per command |
| cmd_cs_n | output | RANKS | Active-low rank selects |
| cmd_addr | output | 18 | Driven A17..A0 |
| cmd_ba | output | 2 | Driven BA1..BA0 |
| cmd_bg | output | 2 | Driven BG1..BG0 |
| cmd_bside | output | 1 | 0 = A-side copy, 1 = B-side copy |
| cmd_tgt | output | 2 | 0 DRAM, 1 register device, 2 data buffer |
| cmd_par | output | 1 | Even parity over the driven word |

## Verification
The first command of a request is due in the cycle after the accepting edge. The B-side copy, or the next request's command, is due exactly max(`gap_cfg`,1) cycles later. The bench logs every command at the falling edge together with a cycle stamp taken at rising edges, so spacing is checked as an exact difference of stamps. It samples nothing in the middle of an edge. Each scenario waits long enough for the longest sequence to drain. It then compares the number of logged commands and each word against expected values built with its own swap and inversion functions.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  localparam int ADDR_W = 18;
  localparam int BA_W   = 2;
  localparam int BG_W   = 2;
  localparam int CAB_W  = ADDR_W + BA_W + BG_W;
  localparam int BA_LSB = ADDR_W;
  localparam int BG_LSB = ADDR_W + BA_W;
  localparam int CW_SEL = 12;
  localparam logic [2:0] CW_INDEX = 3'd7;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_REG  = 2'd1,
    TGT_BUF  = 2'd2
  } tgt_e;

  // Source bit feeding position i when an odd rank is addressed.
  function automatic int mirror_src(input int i);
    int s;
    s = i;
    if (i == 3) s = 4;
    else if (i == 4) s = 3;
    else if (i == 5) s = 6;
    else if (i == 6) s = 5;
    else if (i == 7) s = 8;
    else if (i == 8) s = 7;
    else if (i == 11) s = 13;
    else if (i == 13) s = 11;
    else if (i == BA_LSB) s = BA_LSB + 1;
    else if (i == BA_LSB + 1) s = BA_LSB;
    else if (i == BG_LSB) s = BG_LSB + 1;
    else if (i == BG_LSB + 1) s = BG_LSB;
    return s;
  endfunction

  // Whether position i is flipped by the register device on the B side.
  function automatic bit is_invertible(input int i);
    return (i >= 3 && i <= 9) || i == 11 || i == 13 || i == 17 || i >= BA_LSB;
  endfunction
endpackage

// File: rtl/mrw_remap.sv
module mrw_remap
  import mrw_pkg::*;
(
  input  logic [CAB_W-1:0] cab_i,
  input  logic             mirror_i,
  output logic [CAB_W-1:0] side_a_o,
  output logic [CAB_W-1:0] side_b_o
);
  for (genvar g = 0; g < CAB_W; g++) begin : g_bit
    localparam int SRC = mirror_src(g);
    localparam bit INV = is_invertible(g);
    assign side_a_o[g] = mirror_i ? cab_i[SRC] : cab_i[g];
    if (INV) begin : g_inv
      assign side_b_o[g] = ~side_a_o[g];
    end else begin : g_pass
      assign side_b_o[g] = side_a_o[g];
    end
  end
endmodule

// File: rtl/mrw_parity.sv
module mrw_parity #(
  parameter int W = 22
) (
  input  logic [W-1:0] data_i,
  output logic         par_o
);
  assign par_o = ^data_i;
endmodule

// File: rtl/mrw_gap_timer.sv
module mrw_gap_timer #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             done_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (gap_i == '0) ? '0 : gap_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/mrw_seq.sv
module mrw_seq
  import mrw_pkg::*;
#(
  parameter int RANKS = 4,
  parameter int GAP_W = 6,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [2:0]        req_mr,
  input  logic [17:0]       req_data,
  input  logic              inv_disable,
  input  logic [GAP_W-1:0]  gap_cfg,
  output logic              cmd_valid,
  output logic [RANKS-1:0]  cmd_cs_n,
  output logic [17:0]       cmd_addr,
  output logic [1:0]        cmd_ba,
  output logic [1:0]        cmd_bg,
  output logic              cmd_bside,
  output logic [1:0]        cmd_tgt,
  output logic              cmd_par
);
  logic              pend_b_q;
  logic [CAB_W-1:0]  b_cab_q;
  logic [RANK_W-1:0] b_rank_q;
  logic              gap_done;
  logic              accept;
  logic              issue_b;
  logic              issue;
  logic              is_cw;
  logic              do_mirror;
  logic              two_step;
  tgt_e              req_tgt;
  logic [CAB_W-1:0]  raw_cab;
  logic [CAB_W-1:0]  side_a;
  logic [CAB_W-1:0]  side_b;
  logic [CAB_W-1:0]  next_cab;
  logic [RANK_W-1:0] next_rank;
  logic              next_par;
  logic [RANKS-1:0]  rank_sel;
  logic [CAB_W-1:0]  cmd_cab_q;

  assign req_ready = !pend_b_q && gap_done;
  assign accept    = req_valid && req_ready;
  assign issue_b   = pend_b_q && gap_done;
  assign issue     = accept || issue_b;

  assign is_cw     = (req_mr == CW_INDEX);
  assign do_mirror = req_rank[0] && !is_cw;
  assign two_step  = !inv_disable && !is_cw;
  assign raw_cab   = {1'b0, req_mr[2], req_mr[1:0], req_data};

  always_comb begin
    if (!is_cw)                req_tgt = TGT_DRAM;
    else if (req_data[CW_SEL]) req_tgt = TGT_BUF;
    else                       req_tgt = TGT_REG;
  end

  mrw_remap u_remap (
    .cab_i    (raw_cab),
    .mirror_i (do_mirror),
    .side_a_o (side_a),
    .side_b_o (side_b)
  );

  assign next_cab  = accept ? side_a : b_cab_q;
  assign next_rank = accept ? req_rank : b_rank_q;

  mrw_parity #(.W(CAB_W)) u_parity (
    .data_i (next_cab),
    .par_o  (next_par)
  );

  mrw_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (issue),
    .gap_i  (gap_cfg),
    .done_o (gap_done)
  );

  for (genvar r = 0; r < RANKS; r++) begin : g_cs
    assign rank_sel[r] = (next_rank == RANK_W'(r));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_b_q <= 1'b0;
      b_cab_q  <= '0;
      b_rank_q <= '0;
    end else if (accept) begin
      pend_b_q <= two_step;
      b_cab_q  <= side_b;
      b_rank_q <= req_rank;
    end else if (issue_b) begin
      pend_b_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_cs_n  <= '1;
      cmd_cab_q <= '0;
      cmd_bside <= 1'b0;
      cmd_tgt   <= TGT_DRAM;
      cmd_par   <= 1'b0;
    end else begin
      cmd_valid <= issue;
      cmd_cs_n  <= issue ? ~rank_sel : '1;
      if (issue) begin
        cmd_cab_q <= next_cab;
        cmd_bside <= issue_b;
        cmd_tgt   <= issue_b ? TGT_DRAM : req_tgt;
        cmd_par   <= next_par;
      end
    end
  end

  assign cmd_addr = cmd_cab_q[ADDR_W-1:0];
  assign cmd_ba   = cmd_cab_q[BA_LSB +: BA_W];
  assign cmd_bg   = cmd_cab_q[BG_LSB +: BG_W];
endmodule

// File: rtl/mrw_seq_chk.sv
module mrw_seq_chk
  import mrw_pkg::*;
#(
  parameter int RANKS = 4,
  parameter int GAP_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [GAP_W-1:0] gap_cfg,
  input logic             cmd_valid,
  input logic [RANKS-1:0] cmd_cs_n,
  input logic [17:0]      cmd_addr,
  input logic [1:0]       cmd_ba,
  input logic [1:0]       cmd_bg,
  input logic             cmd_bside,
  input logic [1:0]       cmd_tgt,
  input logic             cmd_par
);
  localparam logic [CAB_W-1:0] INV_MASK = 22'h3E2BF8;
  logic [CAB_W-1:0] cab;
  logic [CAB_W-1:0] last_a_q;
  logic [15:0]      since_q;
  logic [15:0]      min_gap;

  assign cab     = {cmd_bg, cmd_ba, cmd_addr};
  assign min_gap = (gap_cfg == '0) ? 16'd1 : 16'(gap_cfg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_a_q <= '0;
      since_q  <= 16'hFFFF;
    end else begin
      if (cmd_valid && !cmd_bside) last_a_q <= cab;
      if (cmd_valid) since_q <= 16'd1;
      else if (since_q != 16'hFFFF) since_q <= since_q + 16'd1;
    end
  end

  // R2
  accept_issues_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_valid && !cmd_bside));

  // R5
  bside_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_bside) |-> (((cab ^ last_a_q) == INV_MASK) && cmd_tgt == 2'd0));

  // R8
  even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (($countones({cab, cmd_par}) % 2) == 0));

  // R10
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones(~cmd_cs_n) == 1));

  // R10
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (&cmd_cs_n));

  // R9
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (since_q >= min_gap));
endmodule

bind mrw_seq mrw_seq_chk #(.RANKS(RANKS), .GAP_W(GAP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .gap_cfg   (gap_cfg),
  .cmd_valid (cmd_valid),
  .cmd_cs_n  (cmd_cs_n),
  .cmd_addr  (cmd_addr),
  .cmd_ba    (cmd_ba),
  .cmd_bg    (cmd_bg),
  .cmd_bside (cmd_bside),
  .cmd_tgt   (cmd_tgt),
  .cmd_par   (cmd_par)
);

// File: tb/mrw_seq_bench.sv
module mrw_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] INV_MASK = 22'h3E2BF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_rank = '0;
  logic [2:0]  req_mr = '0;
  logic [17:0] req_data = '0;
  logic        inv_disable = 1'b0;
  logic [5:0]  gap_cfg = 6'd2;
  logic        cmd_valid;
  logic [3:0]  cmd_cs_n;
  logic [17:0] cmd_addr;
  logic [1:0]  cmd_ba;
  logic [1:0]  cmd_bg;
  logic        cmd_bside;
  logic [1:0]  cmd_tgt;
  logic        cmd_par;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ncap = 0;
  logic [21:0] cap_cab[4];
  logic [3:0]  cap_cs[4];
  logic        cap_side[4];
  logic [1:0]  cap_tgt[4];
  logic        cap_par[4];
  logic        cap_rdy[4];
  int          cap_cyc[4];

  mrw_seq u_mrw_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rank(req_rank), .req_mr(req_mr), .req_data(req_data),
    .inv_disable(inv_disable), .gap_cfg(gap_cfg), .cmd_valid(cmd_valid),
    .cmd_cs_n(cmd_cs_n), .cmd_addr(cmd_addr), .cmd_ba(cmd_ba), .cmd_bg(cmd_bg),
    .cmd_bside(cmd_bside), .cmd_tgt(cmd_tgt), .cmd_par(cmd_par)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cmd_valid && ncap < 4) begin
      cap_cab[ncap]  = {cmd_bg, cmd_ba, cmd_addr};
      cap_cs[ncap]   = cmd_cs_n;
      cap_side[ncap] = cmd_bside;
      cap_tgt[ncap]  = cmd_tgt;
      cap_par[ncap]  = cmd_par;
      cap_rdy[ncap]  = req_ready;
      cap_cyc[ncap]  = cyc;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] build(input logic [2:0] mr, input logic [17:0] d);
    return {1'b0, mr[2], mr[1], mr[0], d};
  endfunction

  function automatic logic [21:0] swap_odd(input logic [21:0] v);
    logic [21:0] m;
    m = v;
    m[3] = v[4];   m[4] = v[3];
    m[5] = v[6];   m[6] = v[5];
    m[7] = v[8];   m[8] = v[7];
    m[11] = v[13]; m[13] = v[11];
    m[18] = v[19]; m[19] = v[18];
    m[20] = v[21]; m[21] = v[20];
    return m;
  endfunction

  function automatic bit even_par(input logic [21:0] v, input logic p);
    return ($countones({v, p}) % 2) == 0;
  endfunction

  task automatic send(input logic [1:0] rk, input logic [2:0] mr, input logic [17:0] d);
    @(negedge clk);
    req_rank = rk; req_mr = mr; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  // DRAM write: checks count, words, sides, cs, target, parity, spacing.
  task automatic t_dram(input logic [1:0] rk, input logic [2:0] mr, input logic [17:0] d,
                        input string tag);
    logic [21:0] ea;
    int nexp;
    int gap;
    ea   = rk[0] ? swap_odd(build(mr, d)) : build(mr, d);
    nexp = inv_disable ? 1 : 2;
    gap  = (gap_cfg == 0) ? 1 : int'(gap_cfg);
    ncap = 0;
    send(rk, mr, d);
    drain();
    chk(ncap == nexp, {tag, " R5 R6 command count"}, ncap, nexp);
    if (ncap >= 1) begin
      chk(cap_cab[0] == ea, {tag, " R3 R4 A-side word"}, cap_cab[0], ea);
      chk(cap_side[0] == 1'b0, {tag, " R2 first is A side"}, cap_side[0], 0);
      chk(cap_cs[0] == ~(4'b1 << rk), {tag, " R10 chip select"}, cap_cs[0], ~(4'b1 << rk));
      chk(cap_tgt[0] == 2'd0, {tag, " R7 DRAM target"}, cap_tgt[0], 0);
      chk(even_par(cap_cab[0], cap_par[0]), {tag, " R8 parity A"}, cap_par[0], ~cap_par[0]);
    end
    if (nexp == 2 && ncap == 2) begin
      chk(cap_cab[1] == (ea ^ INV_MASK), {tag, " R5 B-side word"}, cap_cab[1], ea ^ INV_MASK);
      chk(cap_side[1] == 1'b1, {tag, " R5 second is B side"}, cap_side[1], 1);
      chk(cap_cs[1] == ~(4'b1 << rk), {tag, " R10 chip select B"}, cap_cs[1], ~(4'b1 << rk));
      chk(even_par(cap_cab[1], cap_par[1]), {tag, " R8 parity B"}, cap_par[1], ~cap_par[1]);
      chk(cap_rdy[0] == 1'b0, {tag, " R2 ready low with B pending"}, cap_rdy[0], 0);
      chk(cap_cyc[1] - cap_cyc[0] == gap, {tag, " R9 A-to-B spacing"},
          cap_cyc[1] - cap_cyc[0], gap);
    end
  endtask

  task automatic t_ctrl(input logic [1:0] rk, input logic [17:0] d, input string tag);
    logic [1:0] et;
    et = d[12] ? 2'd2 : 2'd1;
    ncap = 0;
    send(rk, 3'd7, d);
    drain();
    chk(ncap == 1, {tag, " R7 single control command"}, ncap, 1);
    chk(cap_tgt[0] == et, {tag, " R7 control target"}, cap_tgt[0], et);
    chk(cap_cab[0] == build(3'd7, d), {tag, " R7 control word unmodified"},
        cap_cab[0], build(3'd7, d));
    chk(even_par(cap_cab[0], cap_par[0]), {tag, " R8 parity control"}, cap_par[0], ~cap_par[0]);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1 no command after reset", cmd_valid, 0);
    chk(cmd_cs_n == 4'hF, "R1 selects idle after reset", cmd_cs_n, 4'hF);
  endtask

  task automatic t_back_to_back();
    inv_disable = 1'b1;
    gap_cfg = 6'd3;
    ncap = 0;
    send(2'd0, 3'd1, 18'h00123);
    send(2'd2, 3'd2, 18'h3C00F);
    drain();
    chk(ncap == 2, "R9 two single commands", ncap, 2);
    chk(cap_cyc[1] - cap_cyc[0] == 3, "R9 request-to-request spacing",
        cap_cyc[1] - cap_cyc[0], 3);
    chk(cap_cs[1] == 4'b1011, "R10 rank 2 select", cap_cs[1], 4'b1011);
    inv_disable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    gap_cfg = 6'd2;
    t_dram(2'd0, 3'd3, 18'h2A5C3, "even rank");
    t_dram(2'd1, 3'd5, 18'h02978, "odd rank");
    t_dram(2'd3, 3'd6, 18'h1F0F0, "rank 3");
    gap_cfg = 6'd5;
    t_dram(2'd2, 3'd0, 18'h3FFFF, "gap 5");
    gap_cfg = 6'd0;
    t_dram(2'd1, 3'd4, 18'h00000, "gap 0");
    inv_disable = 1'b1;
    t_dram(2'd1, 3'd2, 18'h028A8, "no inversion");
    inv_disable = 1'b0;
    t_ctrl(2'd1, 18'h01234, "buffer word");
    t_ctrl(2'd0, 18'h02FFF & 18'h2EFFF, "register word");
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule